// File: doc/BRIEF.md
# Write-Only Two-Wire Control Register Slave

This block is a two-wire serial bus target for a small bank of 8-bit control registers. It accepts write transfers only. A controller sends a START, then a device byte, then a register pointer byte, then any number of data bytes, and ends with a STOP. Each data byte lands in the register the pointer selects, and the pointer then advances. After the last register the pointer wraps back to the first one. The block acknowledges every byte it accepts. It never answers a read request or a device address that is not its own.

The clock line and the data line are oversampled by a fast system clock through synchroniser flops. START and STOP are recognised from the order in which the lines change. The open-drain data output is modelled as a single pull-low enable. The lowest bit of the device address comes from a strap input, so two of these targets can share one bus.

The bank holds a register-reset bit. While that bit is 1, every other register is held at its power-on value. The reset bit itself stays set until a controller writes it back to 0. The full bank is presented on a flat output vector, register 0 in the lowest byte.

Top module: `i2c_ctrl_slave`

## Requirements
- R1: After rst_n is released, the registers read 0x8B, 0x02, 0x00, 0xFF and 0xFF for indices 0 to 4. Register i appears at regs_o[8*i+7:8*i].
- R2: A first byte whose bits 7:1 equal 001000 followed by the strap value, and whose bit 0 is 0, is acknowledged. The acknowledge is sda_pull_o high during the high phase of the ninth SCL pulse.
- R3: A first byte with bit 0 = 1, or with a mismatched address, is not acknowledged. No further byte is acknowledged or written until the next START.
- R4: The second byte is acknowledged, and its bits 2:0 load the register pointer. Each later byte is acknowledged and written to the pointed register, and the pointer then advances by one.
- R5: After a write at pointer 4, the pointer wraps to 0. A pointer value of 5, 6 or 7 discards the data byte, still acknowledges it, and moves the pointer to 0.
- R6: A START received at any point, including inside a byte, abandons the partial byte and restarts address matching. The partial byte writes nothing.
- R7: After a STOP, bytes clocked without a new START are neither acknowledged nor written.
- R8: While bit 7 of register 2 is 1, all other registers hold their R1 values and writes to them are lost. Register 2 then reads 0x80. Writing 0 to that bit releases the hold.
- R9: The target never pulls SDA low during the eight data bit periods of a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level as seen on the wire |
| addr_strap_i | input | 1 | Strap that sets the lowest device address bit |
| sda_pull_o | output | 1 | When high, the data line is driven low |
| regs_o | output | NUM_REGS*8 | Register contents, register i in byte i |

## Verification
The bench builds the block with its default parameters: five registers, two synchroniser stages, address prefix 001000, and the register-reset bit at bit 7 of register 2. With five registers the pointer wrap and the unused pointer codes 5 to 7 both fall inside a 3-bit pointer, so each can be reached in a single burst. The bench runs SCL at eight system clocks per half period and drives the strap both ways. A behavioural model of the registers is compared with the outputs on every clock outside the short window in which a byte is being written.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
   // Transfer phase of the write-only target.
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,   // waiting for START or ignoring the bus
      PH_DEV  = 2'd1,   // receiving the device byte
      PH_REG  = 2'd2,   // receiving the register pointer
      PH_DATA = 2'd3    // receiving data bytes
   } phase_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det,
   output logic sda_bit
);
   logic [STAGES-1:0] scl_sh, sda_sh;
   logic              scl_q, sda_q;
   logic              scl_s, sda_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_sh <= '1;
         sda_sh <= '1;
         scl_q  <= 1'b1;
         sda_q  <= 1'b1;
      end else begin
         scl_sh <= {scl_sh[STAGES-2:0], scl_i};
         sda_sh <= {sda_sh[STAGES-2:0], sda_i};
         scl_q  <= scl_sh[STAGES-1];
         sda_q  <= sda_sh[STAGES-1];
      end
   end

   assign scl_s     = scl_sh[STAGES-1];
   assign sda_s     = sda_sh[STAGES-1];
   assign scl_rise  = scl_s & ~scl_q;
   assign scl_fall  = ~scl_s & scl_q;
   // Data edges while the clock stays high mark bus conditions.
   assign start_det = scl_s & scl_q & sda_q & ~sda_s;
   assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
   assign sda_bit   = sda_s;
endmodule

// File: rtl/i2c_wr_fsm.sv
module i2c_wr_fsm
   import i2c_cfg_pkg::*;
#(
   parameter int         NUM_REGS    = 5,
   parameter int         PTR_W       = 3,
   parameter logic [5:0] DEV_ADDR_HI = 6'b001000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic             sda_bit,
   input  logic             strap,
   output logic             sda_pull,
   output logic             wr_en,
   output logic [PTR_W-1:0] wr_idx,
   output logic [7:0]       wr_data
);
   localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(NUM_REGS - 1);

   phase_t           phase;
   logic [7:0]       shreg;
   logic [3:0]       bit_cnt;
   logic             ack_ph;
   logic [PTR_W-1:0] ptr;
   logic             byte_done;
   logic             dev_hit;
   logic [PTR_W-1:0] ptr_next;

   assign byte_done = scl_fall && !ack_ph && (bit_cnt == 4'd8) && (phase != PH_IDLE);
   assign dev_hit   = (shreg[7:1] == {DEV_ADDR_HI, strap}) && !shreg[0];
   assign ptr_next  = (ptr >= LAST_PTR) ? '0 : ptr + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         shreg    <= '0;
         bit_cnt  <= '0;
         ack_ph   <= 1'b0;
         ptr      <= '0;
         sda_pull <= 1'b0;
         wr_en    <= 1'b0;
         wr_idx   <= '0;
         wr_data  <= '0;
      end else if (start_det) begin
         phase    <= PH_DEV;
         bit_cnt  <= '0;
         ack_ph   <= 1'b0;
         sda_pull <= 1'b0;
         wr_en    <= 1'b0;
      end else if (stop_det) begin
         phase    <= PH_IDLE;
         bit_cnt  <= '0;
         ack_ph   <= 1'b0;
         sda_pull <= 1'b0;
         wr_en    <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (scl_rise && !ack_ph && bit_cnt < 4'd8 && phase != PH_IDLE) begin
            shreg   <= {shreg[6:0], sda_bit};
            bit_cnt <= bit_cnt + 1'b1;
         end
         if (byte_done) begin
            ack_ph <= 1'b1;
            unique case (phase)
               PH_DEV: begin
                  sda_pull <= dev_hit;
                  phase    <= dev_hit ? PH_REG : PH_IDLE;
               end
               PH_REG: begin
                  sda_pull <= 1'b1;
                  ptr      <= shreg[PTR_W-1:0];
                  phase    <= PH_DATA;
               end
               PH_DATA: begin
                  sda_pull <= 1'b1;
                  wr_en    <= (ptr < PTR_W'(NUM_REGS));
                  wr_idx   <= ptr;
                  wr_data  <= shreg;
                  ptr      <= ptr_next;
               end
               default: phase <= PH_IDLE;
            endcase
         end else if (ack_ph && scl_fall) begin
            ack_ph   <= 1'b0;
            sda_pull <= 1'b0;
            bit_cnt  <= '0;
         end
      end
   end

   // R5: the pointer returns to zero after the last register is written
   p_ptr_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && !start_det && !stop_det && phase == PH_DATA && ptr == LAST_PTR) |=> (ptr == '0));

   // R6: a START drops any acknowledge and restarts address matching
   p_start_restart_r6: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> (!sda_pull && phase == PH_DEV && !wr_en));

   // R3: a read request is never acknowledged
   p_read_nack_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && !start_det && !stop_det && phase == PH_DEV && shreg[0]) |=> !sda_pull);

   // R9: the data line is only pulled right after a completed byte
   p_pull_after_byte_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull) |-> $past(byte_done));
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank #(
   parameter int                      NUM_REGS = 5,
   parameter int                      PTR_W    = 3,
   parameter logic [NUM_REGS*8-1:0]   DEFAULTS = '0,
   parameter int                      RRST_IDX = 2,
   parameter int                      RRST_BIT = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [PTR_W-1:0]      wr_idx,
   input  logic [7:0]            wr_data,
   output logic [NUM_REGS*8-1:0] regs_flat
);
   localparam int LOC = RRST_IDX * 8 + RRST_BIT;

   logic rrst_cur, rrst_next;

   assign rrst_cur  = regs_flat[LOC];
   assign rrst_next = (wr_en && wr_idx == PTR_W'(RRST_IDX)) ? wr_data[RRST_BIT] : rrst_cur;

   for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
      localparam logic [7:0] DEF      = DEFAULTS[g*8 +: 8];
      localparam logic [7:0] HOLD_VAL = (g == RRST_IDX) ? (DEF | (8'h01 << RRST_BIT)) : DEF;
      logic [7:0] r_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                              r_q <= DEF;
         else if (rrst_next)                      r_q <= HOLD_VAL;
         else if (wr_en && wr_idx == PTR_W'(g))   r_q <= wr_data;
      end
      assign regs_flat[g*8 +: 8] = r_q;

      if (g != RRST_IDX) begin : g_chk
         // R8: other registers sit at their defaults while the reset bit is set
         p_rrst_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            rrst_cur |-> (r_q == DEF));
      end

      // R4: an accepted write shows up in the addressed register
      p_write_lands_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_idx == PTR_W'(g) && !rrst_next) |=> (r_q == $past(wr_data)));
   end
endmodule

// File: rtl/i2c_ctrl_slave.sv
module i2c_ctrl_slave #(
   parameter int                      NUM_REGS    = 5,
   parameter int                      SYNC_STAGES = 2,
   parameter logic [5:0]              DEV_ADDR_HI = 6'b001000,
   parameter logic [NUM_REGS*8-1:0]   REG_DEFAULTS = 40'hFF_FF_00_02_8B,
   parameter int                      RRST_IDX    = 2,
   parameter int                      RRST_BIT    = 7
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   input  logic                  addr_strap_i,
   output logic                  sda_pull_o,
   output logic [NUM_REGS*8-1:0] regs_o
);
   localparam int PTR_W = 3;

   if (NUM_REGS < 2 || NUM_REGS > (1 << PTR_W)) begin : g_bad_regs
      $error("NUM_REGS must lie between 2 and the pointer range");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (RRST_IDX >= NUM_REGS || RRST_BIT > 7) begin : g_bad_rrst
      $error("register-reset location out of range");
   end

   logic             scl_rise, scl_fall, start_det, stop_det, sda_bit;
   logic             wr_en;
   logic [PTR_W-1:0] wr_idx;
   logic [7:0]       wr_data;

   i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det),
      .sda_bit  (sda_bit)
   );

   i2c_wr_fsm #(
      .NUM_REGS   (NUM_REGS),
      .PTR_W      (PTR_W),
      .DEV_ADDR_HI(DEV_ADDR_HI)
   ) u_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_det(start_det),
      .stop_det (stop_det),
      .sda_bit  (sda_bit),
      .strap    (addr_strap_i),
      .sda_pull (sda_pull_o),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data)
   );

   ctrl_reg_bank #(
      .NUM_REGS(NUM_REGS),
      .PTR_W   (PTR_W),
      .DEFAULTS(REG_DEFAULTS),
      .RRST_IDX(RRST_IDX),
      .RRST_BIT(RRST_BIT)
   ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .wr_data  (wr_data),
      .regs_flat(regs_o)
   );
endmodule

// File: tb/i2c_ctrl_slave_tb_top.sv
module i2c_ctrl_slave_tb_top;
   localparam int HP = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        scl = 1'b1;
   logic        sda_m = 1'b1;
   logic        strap = 1'b0;
   logic        sda_pull;
   logic [39:0] regs;
   logic        sda_bus;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   bit cmp_en = 1'b0;

   // behavioural model
   logic [7:0] exp_r [5];
   int mstate = 0;   // 0 ignore, 1 device byte, 2 pointer byte, 3 data
   int mptr = 0;

   always #10 clk = ~clk;

   assign sda_bus = sda_m & ~sda_pull;

   i2c_ctrl_slave dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .scl_i       (scl),
      .sda_i       (sda_bus),
      .addr_strap_i(strap),
      .sda_pull_o  (sda_pull),
      .regs_o      (regs)
   );

   task automatic chk(input bit ok, input string req, input int act, input int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic model_defaults();
      exp_r[0] = 8'h8B; exp_r[1] = 8'h02; exp_r[2] = 8'h00;
      exp_r[3] = 8'hFF; exp_r[4] = 8'hFF;
   endtask

   task automatic model_write(input int idx, input logic [7:0] d);
      if (idx < 5) exp_r[idx] = d;
      if (exp_r[2][7]) begin
         model_defaults();
         exp_r[2] = 8'h80;
      end
   endtask

   // per-clock comparison of the whole bank (R4, R8)
   always @(negedge clk) begin
      if (rst_n && cmp_en && !done) begin
         for (int i = 0; i < 5; i++) begin
            checks++;
            if (regs[i*8 +: 8] !== exp_r[i]) begin
               errors++;
               $display("FAIL R4 reg%0d actual=%0h expected=%0h", i, regs[i*8 +: 8], exp_r[i]);
            end
         end
      end
   end

   task automatic wt(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bus_start();
      sda_m = 1'b1; wt(HP);
      scl = 1'b1;   wt(HP);
      sda_m = 1'b0; wt(HP);
      scl = 1'b0;   wt(HP);
      mstate = 1;
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wt(HP);
      scl = 1'b1;   wt(HP);
      sda_m = 1'b1; wt(HP);
      mstate = 0;
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; wt(HP);
         scl = 1'b1;   wt(HP/2);
         chk(sda_pull == 1'b0, "R9 pull in data bit", sda_pull, 0);
         wt(HP/2);
         scl = 1'b0;   wt(2);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, input string req);
      bit ea;
      case (mstate)
         1: ea = (b[7:1] == {6'b001000, strap}) && !b[0];
         2, 3: ea = 1'b1;
         default: ea = 1'b0;
      endcase
      send_bits(b, 7);
      sda_m = b[0]; wt(HP);
      scl = 1'b1;   wt(HP/2);
      chk(sda_pull == 1'b0, "R9 pull in data bit", sda_pull, 0);
      wt(HP/2);
      cmp_en = 1'b0;
      scl = 1'b0;
      case (mstate)
         1: mstate = ea ? 2 : 0;
         2: begin mptr = int'(b[2:0]); mstate = 3; end
         3: begin model_write(mptr, b); mptr = (mptr >= 4) ? 0 : mptr + 1; end
         default: ;
      endcase
      wt(2);
      sda_m = 1'b1; wt(HP);
      scl = 1'b1;   wt(HP/2);
      chk(sda_pull == ea, req, sda_pull, ea);
      wt(HP/2);
      scl = 1'b0;   wt(HP);
      cmp_en = 1'b1;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      model_defaults();
      wt(5);
      rst_n = 1'b1;
      wt(3);
      // R1: reset values
      chk(regs[7:0]   == 8'h8B, "R1 reg0", regs[7:0], 8'h8B);
      chk(regs[15:8]  == 8'h02, "R1 reg1", regs[15:8], 8'h02);
      chk(regs[23:16] == 8'h00, "R1 reg2", regs[23:16], 8'h00);
      chk(regs[31:24] == 8'hFF, "R1 reg3", regs[31:24], 8'hFF);
      chk(regs[39:32] == 8'hFF, "R1 reg4", regs[39:32], 8'hFF);
      chk(sda_pull == 1'b0, "R1 idle pull", sda_pull, 0);
      cmp_en = 1'b1;

      // R2, R4: single write to register 3
      bus_start();
      send_byte(8'h20, "R2 device ack");
      send_byte(8'h03, "R4 pointer ack");
      send_byte(8'h40, "R4 data ack");
      bus_stop();
      chk(regs[31:24] == 8'h40, "R4 reg3 written", regs[31:24], 8'h40);

      // R5: burst from register 3 wraps to 0 and 1
      bus_start();
      send_byte(8'h20, "R2 device ack");
      send_byte(8'h03, "R4 pointer ack");
      send_byte(8'h11, "R4 data ack");
      send_byte(8'h22, "R4 data ack");
      send_byte(8'h33, "R5 wrapped data ack");
      send_byte(8'h44, "R5 wrapped data ack");
      bus_stop();
      chk(regs[7:0] == 8'h33 && regs[15:8] == 8'h44, "R5 wrap to reg0", regs[15:0], 16'h4433);

      // R3: read request is refused and following bytes ignored
      bus_start();
      send_byte(8'h21, "R3 read nack");
      send_byte(8'h00, "R3 ignored byte");
      send_byte(8'h99, "R3 ignored byte");
      bus_stop();
      chk(regs[7:0] == 8'h33, "R3 reg0 untouched", regs[7:0], 8'h33);

      // R3: mismatched strap bit
      bus_start();
      send_byte(8'h22, "R3 address mismatch nack");
      send_byte(8'h01, "R3 ignored byte");
      bus_stop();

      // R2: strap high moves the address
      strap = 1'b1;
      bus_start();
      send_byte(8'h22, "R2 strap device ack");
      send_byte(8'h01, "R4 pointer ack");
      send_byte(8'h5C, "R4 data ack");
      bus_stop();
      chk(regs[15:8] == 8'h5C, "R2 strap write reg1", regs[15:8], 8'h5C);

      // R5: out-of-range pointer discards and wraps to 0
      bus_start();
      send_byte(8'h22, "R2 device ack");
      send_byte(8'h06, "R5 pointer ack");
      send_byte(8'hEE, "R5 discarded data ack");
      send_byte(8'h07, "R5 data after wrap ack");
      bus_stop();
      chk(regs[7:0] == 8'h07, "R5 reg0 after discard", regs[7:0], 8'h07);

      // R6: START inside a byte abandons it
      bus_start();
      send_byte(8'h22, "R2 device ack");
      send_byte(8'h00, "R4 pointer ack");
      send_bits(8'hAA, 5);
      bus_start();
      send_byte(8'h22, "R6 device ack after restart");
      send_byte(8'h04, "R6 pointer ack");
      send_byte(8'h5A, "R6 data ack");
      bus_stop();
      chk(regs[7:0] == 8'h07, "R6 partial byte not written", regs[7:0], 8'h07);
      chk(regs[39:32] == 8'h5A, "R6 reg4 written", regs[39:32], 8'h5A);

      // R7: bytes after STOP without START are ignored
      scl = 1'b0; wt(HP);
      send_byte(8'h22, "R7 no ack after stop");
      send_byte(8'h00, "R7 no ack after stop");
      send_byte(8'h12, "R7 no ack after stop");
      chk(regs[7:0] == 8'h07, "R7 reg0 untouched", regs[7:0], 8'h07);
      sda_m = 1'b0; wt(HP);
      scl = 1'b1; wt(HP);
      sda_m = 1'b1; wt(HP);

      // R8: register-reset bit holds the others at default
      bus_start();
      send_byte(8'h22, "R2 device ack");
      send_byte(8'h02, "R4 pointer ack");
      send_byte(8'h98, "R8 reset bit ack");
      send_byte(8'h12, "R8 held write ack");
      bus_stop();
      chk(regs[23:16] == 8'h80, "R8 reg2 keeps bit", regs[23:16], 8'h80);
      chk(regs[7:0] == 8'h8B, "R8 reg0 default", regs[7:0], 8'h8B);
      chk(regs[31:24] == 8'hFF, "R8 reg3 write lost", regs[31:24], 8'hFF);
      chk(regs[39:32] == 8'hFF, "R8 reg4 default", regs[39:32], 8'hFF);

      bus_start();
      send_byte(8'h22, "R2 device ack");
      send_byte(8'h02, "R4 pointer ack");
      send_byte(8'h00, "R8 release ack");
      send_byte(8'h12, "R8 write after release ack");
      bus_stop();
      chk(regs[31:24] == 8'h12, "R8 reg3 after release", regs[31:24], 8'h12);
      chk(regs[23:16] == 8'h00, "R8 reg2 cleared", regs[23:16], 8'h00);

      wt(20);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule